// File: doc/BRIEF.md
# Two-Wire Register-File Slave with Time Snapshot Hold

This block is a serial slave on a two-wire bus. It gives byte access to a 64-location register space that lives outside the block, through a simple read/write port. A transfer opens with a START condition and a device address byte. In a write, the next byte becomes the location pointer and every later byte is stored at the pointer. In a read, bytes are sent starting at the pointer. The pointer keeps its value between transfers, so a read that skips the location byte carries on from where the last access left off.

The bus lines are brought through a synchroniser and sampled by a system clock that runs at least eight times faster than SCL. While the slave is addressed and the pointer sits in the first eight locations, `time_hold` tells a timekeeping core to stop copying live time into those locations, so a multi-byte read sees one consistent value. A power-fail flag ends any access, clears the pointer and blinds the slave to the bus for as long as the flag is high.

Top module: `twowire_regport`

## Requirements
- R1: The slave answers only to address byte D0h (bit 0 = 0, write) or D1h (bit 0 = 1, read). Any other address gets no acknowledge, and the rest of that transfer produces no register write.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START during any phase returns the slave to address matching without a STOP.
- R3: The slave acknowledges by pulling SDA low for the whole ninth clock after a matching address, after the location byte, and after each written data byte. SDA driven by the slave changes only while SCL is low.
- R4: In a write, the first byte after the address loads the pointer (its low 6 bits). Each later byte gives a single-cycle `reg_we` with `reg_addr` equal to the pointer. The pointer then advances when the acknowledge clock ends.
- R5: In a read, the byte at the pointer is sent MSB first. The pointer advances only when the master acknowledges. On a master NACK the slave releases SDA, leaves the pointer unchanged and waits for START or STOP.
- R6: A read sent without a location byte starts at the pointer value left by the previous transfer.
- R7: `time_hold` is high while the slave is addressed and the pointer is below 08h. It falls on STOP, or as soon as the pointer reaches 08h or above.
- R8: While `pwr_fail` is high, the access is aborted, the pointer is cleared to 00h, `sda_oe`, `reg_we` and `time_hold` are low, and bus activity is ignored until a fresh START after the flag drops.
- R9: The pointer wraps from 3Fh to 00h.
- R10: After reset, `sda_oe`, `reg_we` and `time_hold` are low and `reg_addr` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| pwr_fail | input | 1 | Supply out of tolerance; aborts and blinds the slave |
| reg_addr | output | 6 | Location pointer, used for both reads and writes |
| reg_wdata | output | 8 | Byte to store |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Byte at `reg_addr`, read combinationally |
| time_hold | output | 1 | Freezes time updates in locations 00h-07h |

## Verification
A wrong pointer shows up first as a misplaced byte. A write lands one location off in the external memory, or a read that skips the location byte returns a neighbour's value. This is visible within the next transfer. A bit counter that is off by one moves the acknowledge slot, so the master sees a NACK in the same byte, or the data comes back shifted. A hold flag that fails to clear stays high after STOP, and the port shows it within a few system cycles of the stop condition. The bench therefore pairs every write with a bus readback. It also reads the current pointer back through a read with no location byte after each corner case (wrap, NACK, foreign address, power fail).

// File: rtl/twr_pkg.sv
package twr_pkg;
   localparam int unsigned TWR_BYTE_W = 8;
   localparam logic [3:0]  TWR_LAST_BIT = 4'd8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WORD,
      ST_WR,
      ST_RD
   } twr_state_t;
endpackage

// File: rtl/twr_edge.sv
module twr_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_p, sda_p;

   initial begin
      assert (STAGES >= 2) else $error("twr_edge: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_i};
         sda_q <= {sda_q[STAGES-2:0], sda_i};
         scl_p <= scl_q[STAGES-1];
         sda_p <= sda_q[STAGES-1];
      end
   end

   assign scl_s    = scl_q[STAGES-1];
   assign sda_s    = sda_q[STAGES-1];
   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twr_ptr.sv
module twr_ptr #(
   parameter int unsigned PTR_W      = 6,
   parameter int unsigned CLOCK_REGS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [PTR_W-1:0] load_val,
   input  logic             inc,
   input  logic             busy_set,
   input  logic             busy_clr,
   output logic [PTR_W-1:0] ptr,
   output logic             hold
);
   localparam logic [PTR_W-1:0] CLK_LIM = PTR_W'(CLOCK_REGS);

   logic busy;

   initial begin
      assert (CLOCK_REGS < (1 << PTR_W)) else $error("twr_ptr: CLOCK_REGS exceeds space");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr  <= '0;
         busy <= 1'b0;
      end else if (clr) begin
         ptr  <= '0;
         busy <= 1'b0;
      end else begin
         if (load)     ptr <= load_val;
         else if (inc) ptr <= ptr + 1'b1;
         if (busy_clr)      busy <= 1'b0;
         else if (busy_set) busy <= 1'b1;
      end
   end

   assign hold = busy && (ptr < CLK_LIM);

   assert_clear_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ptr == '0 && !hold));
   assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && !clr && ptr == '1) |=> (ptr == '0));
   assert_hold_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_clr && !clr) |=> !hold);
endmodule

// File: rtl/twowire_regport.sv
module twowire_regport
   import twr_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h68,
   parameter int unsigned PTR_W       = 6,
   parameter int unsigned CLOCK_REGS  = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic             pwr_fail,
   output logic [PTR_W-1:0] reg_addr,
   output logic [7:0]       reg_wdata,
   output logic             reg_we,
   input  logic [7:0]       reg_rdata,
   output logic             time_hold
);
   logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

   twr_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   twr_state_t            state;
   logic [3:0]            bitcnt;
   logic                  in_ack, ack_drv, mack, rd_dir, load_pend, we_q;
   logic [TWR_BYTE_W-1:0] rx, tx, wdata_q;

   // byte-level events, valid only when no bus condition overrides them
   logic ev_ok, byte_end, ack_end, dev_match;
   assign ev_ok     = !pwr_fail && !start_ev && !stop_ev && state != ST_IDLE && scl_fall;
   assign byte_end  = ev_ok && !in_ack && bitcnt == TWR_LAST_BIT;
   assign ack_end   = ev_ok && in_ack;
   assign dev_match = rx[7:1] == DEV_ADDR;

   logic p_load, p_inc, p_bset, p_bclr;
   assign p_load = byte_end && state == ST_WORD;
   assign p_inc  = ack_end && (state == ST_WR || (state == ST_RD && !mack));
   assign p_bset = byte_end && state == ST_DEV && dev_match;
   assign p_bclr = (!pwr_fail && stop_ev) || (byte_end && state == ST_DEV && !dev_match);

   twr_ptr #(.PTR_W(PTR_W), .CLOCK_REGS(CLOCK_REGS)) u_ptr (
      .clk(clk), .rst_n(rst_n), .clr(pwr_fail), .load(p_load),
      .load_val(rx[PTR_W-1:0]), .inc(p_inc), .busy_set(p_bset), .busy_clr(p_bclr),
      .ptr(reg_addr), .hold(time_hold)
   );

   initial begin
      assert (PTR_W <= TWR_BYTE_W) else $error("twowire_regport: PTR_W wider than a byte");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; bitcnt <= '0; in_ack <= 1'b0; ack_drv <= 1'b0;
         mack <= 1'b1; rd_dir <= 1'b0; load_pend <= 1'b0; we_q <= 1'b0;
         rx <= '0; tx <= '1; wdata_q <= '0;
      end else if (pwr_fail) begin
         state <= ST_IDLE; bitcnt <= '0; in_ack <= 1'b0; ack_drv <= 1'b0;
         load_pend <= 1'b0; we_q <= 1'b0; tx <= '1;
      end else begin
         we_q      <= 1'b0;
         load_pend <= 1'b0;
         if (load_pend) tx <= reg_rdata;
         if (start_ev || stop_ev) begin
            state   <= start_ev ? ST_DEV : ST_IDLE;
            bitcnt  <= '0;
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
         end else if (state != ST_IDLE) begin
            if (scl_rise) begin
               if (in_ack) mack <= sda_s;
               else if (bitcnt < TWR_LAST_BIT) begin
                  rx     <= {rx[TWR_BYTE_W-2:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end
            end else if (byte_end) begin
               in_ack <= 1'b1;
               unique case (state)
                  ST_DEV: begin
                     if (dev_match) begin
                        ack_drv <= 1'b1;
                        rd_dir  <= rx[0];
                     end else begin
                        state  <= ST_IDLE;
                        in_ack <= 1'b0;
                        bitcnt <= '0;
                     end
                  end
                  ST_WORD: ack_drv <= 1'b1;
                  ST_WR: begin
                     ack_drv <= 1'b1;
                     we_q    <= 1'b1;
                     wdata_q <= rx;
                  end
                  default: ack_drv <= 1'b0;
               endcase
            end else if (ack_end) begin
               in_ack  <= 1'b0;
               bitcnt  <= '0;
               ack_drv <= 1'b0;
               unique case (state)
                  ST_DEV: begin
                     state     <= rd_dir ? ST_RD : ST_WORD;
                     load_pend <= rd_dir;
                  end
                  ST_WORD: state <= ST_WR;
                  ST_RD: begin
                     if (mack) state <= ST_IDLE;
                     else      load_pend <= 1'b1;
                  end
                  default: state <= state;
               endcase
            end else if (scl_fall && state == ST_RD && bitcnt != 4'd0) begin
               tx <= {tx[TWR_BYTE_W-2:0], 1'b1};
            end
         end
      end
   end

   assign sda_oe    = ack_drv || (state == ST_RD && !in_ack && !tx[TWR_BYTE_W-1]);
   assign reg_we    = we_q;
   assign reg_wdata = wdata_q;

   assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);
   assert_sda_moves_low_scl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(pwr_fail) && sda_oe != $past(sda_oe)) |-> !scl_s);
   assert_fail_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> (!sda_oe && !reg_we));
endmodule

// File: tb/twowire_regport_tb.sv
module twowire_regport_tb;
   localparam int CLK_PERIOD = 10;
   localparam int H = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, pwr_fail = 1'b0;
   logic sda_oe, reg_we, time_hold;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic sda_line;
   logic [7:0] mem [64];
   int n_chk = 0, n_fail = 0, we_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;
   assign reg_rdata = mem[reg_addr];

   twowire_regport u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .pwr_fail(pwr_fail), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .reg_rdata(reg_rdata), .time_hold(time_hold)
   );

   function automatic logic [7:0] init_val(input int i);
      return 8'(i * 7 + 3);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
      end else if (reg_we) mem[reg_addr] <= reg_wdata;
   end

   always @(posedge clk) if (reg_we) we_cnt <= we_cnt + 1;

   // location, data
   localparam logic [13:0] VEC [6] = '{
      {6'h08, 8'h5A}, {6'h13, 8'hC3}, {6'h14, 8'h00},
      {6'h2A, 8'hFF}, {6'h3F, 8'h81}, {6'h00, 8'h7E}
   };

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_start;
      sda_m = 1'b1; wait_cyc(H);
      scl_m = 1'b1; wait_cyc(H);
      sda_m = 1'b0; wait_cyc(H);
      scl_m = 1'b0; wait_cyc(2);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wait_cyc(H);
      scl_m = 1'b1; wait_cyc(H);
      sda_m = 1'b1; wait_cyc(H);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic nack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wait_cyc(H);
         scl_m = 1'b1; wait_cyc(H);
         scl_m = 1'b0; wait_cyc(2);
      end
      sda_m = 1'b1; wait_cyc(H);
      scl_m = 1'b1; wait_cyc(H/2);
      nack = sda_line; wait_cyc(H/2);
      scl_m = 1'b0; wait_cyc(2);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wait_cyc(H);
         scl_m = 1'b1; wait_cyc(H/2);
         b[i] = sda_line; wait_cyc(H/2);
         scl_m = 1'b0; wait_cyc(2);
      end
      sda_m = !give_ack; wait_cyc(H);
      scl_m = 1'b1; wait_cyc(H);
      scl_m = 1'b0; wait_cyc(2);
      sda_m = 1'b1;
   endtask

   task automatic read_current(output logic [7:0] b, output logic nack);
      bus_start; send_byte(8'hD1, nack); recv_byte(1'b0, b); bus_stop;
   endtask

   task automatic set_ptr(input logic [5:0] a, output logic nack);
      logic n1, n2;
      bus_start; send_byte(8'hD0, n1); send_byte({2'b00, a}, n2); bus_stop;
      nack = n1 | n2;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic n0, n1, n2, n3;
      logic [7:0] rb, rb2, rb3;
      int we0;
      wait_cyc(5);
      // R10: reset state
      check("R10 sda_oe", {7'd0, sda_oe}, 8'd0);
      check("R10 time_hold", {7'd0, time_hold}, 8'd0);
      check("R10 reg_we", {7'd0, reg_we}, 8'd0);
      check("R10 reg_addr", {2'b00, reg_addr}, 8'd0);
      rst_n = 1'b1;
      wait_cyc(5);

      // R4/R2/R3: table walk, write then readback with repeated START
      foreach (VEC[k]) begin
         bus_start; send_byte(8'hD0, n0); send_byte({2'b00, VEC[k][13:8]}, n1);
         send_byte(VEC[k][7:0], n2); bus_stop;
         check("R3 acks on write", {5'd0, n0, n1, n2}, 8'd0);
         bus_start; send_byte(8'hD0, n0); send_byte({2'b00, VEC[k][13:8]}, n1);
         bus_start; send_byte(8'hD1, n2); recv_byte(1'b0, rb); bus_stop;
         check("R3 acks on readback", {5'd0, n0, n1, n2}, 8'd0);
         check("R4 R2 readback data", rb, VEC[k][7:0]);
      end

      // R9: wrap from 3Fh, then R6 current-address read
      bus_start; send_byte(8'hD0, n0); send_byte(8'h3E, n1);
      send_byte(8'h11, n2); send_byte(8'h22, n2); send_byte(8'h33, n3); bus_stop;
      wait_cyc(4);
      check("R9 mem3E", mem[6'h3E], 8'h11);
      check("R9 mem3F", mem[6'h3F], 8'h22);
      check("R9 mem00 after wrap", mem[6'h00], 8'h33);
      read_current(rb, n0);
      check("R6 current read after wrap", rb, init_val(1));

      // R5: sequential read, advance only on master ACK
      set_ptr(6'h14, n0);
      bus_start; send_byte(8'hD1, n0);
      recv_byte(1'b1, rb); recv_byte(1'b1, rb2); recv_byte(1'b0, rb3); bus_stop;
      check("R5 seq byte0", rb, 8'h00);
      check("R5 seq byte1", rb2, init_val(8'h15));
      check("R5 seq byte2", rb3, init_val(8'h16));
      check("R5 sda released after NACK", {7'd0, sda_oe}, 8'd0);
      read_current(rb, n0);
      check("R5 NACK left pointer", rb, init_val(8'h16));

      // R7: hold while pointer below 08h
      bus_start; send_byte(8'hD0, n0); send_byte(8'h05, n1);
      wait_cyc(4);
      check("R7 hold in clock range", {7'd0, time_hold}, 8'd1);
      send_byte(8'hA5, n2); send_byte(8'hA6, n2); send_byte(8'hA7, n2);
      wait_cyc(4);
      check("R7 hold drops at 08h", {7'd0, time_hold}, 8'd0);
      bus_stop;
      bus_start; send_byte(8'hD0, n0); send_byte(8'h02, n1);
      wait_cyc(4);
      check("R7 hold again", {7'd0, time_hold}, 8'd1);
      bus_stop; wait_cyc(4);
      check("R7 hold drops on STOP", {7'd0, time_hold}, 8'd0);

      // R1: foreign address ignored
      we0 = we_cnt;
      bus_start; send_byte(8'hA0, n0); send_byte(8'h30, n1); send_byte(8'hEE, n2); bus_stop;
      wait_cyc(4);
      check("R1 foreign address NACK", {7'd0, n0}, 8'd1);
      check("R1 no write", 8'(we_cnt - we0), 8'd0);
      read_current(rb, n0);
      check("R1 pointer kept", rb, init_val(2));

      // R2: repeated START in a write
      bus_start; send_byte(8'hD0, n0); send_byte(8'h31, n1); send_byte(8'h44, n2);
      bus_start; send_byte(8'hD0, n0); send_byte(8'h32, n1); send_byte(8'h55, n2); bus_stop;
      wait_cyc(4);
      check("R2 before restart", mem[6'h31], 8'h44);
      check("R2 after restart", mem[6'h32], 8'h55);

      // R8: power fail mid-write
      bus_start; send_byte(8'hD0, n0); send_byte(8'h03, n1); send_byte(8'h9A, n2);
      wait_cyc(2);
      pwr_fail = 1'b1;
      wait_cyc(3);
      check("R8 hold off", {7'd0, time_hold}, 8'd0);
      send_byte(8'h77, n3);
      check("R8 no ack during fail", {7'd0, n3}, 8'd1);
      pwr_fail = 1'b0;
      send_byte(8'h66, n3);
      bus_stop; wait_cyc(4);
      check("R8 write before fail", mem[6'h03], 8'h9A);
      check("R8 bytes after fail ignored", mem[6'h04], init_val(4));
      read_current(rb, n0);
      check("R8 pointer cleared", rb, 8'h33);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule